// File: doc/BRIEF.md
# Packed Event Record Stream Decoder

This block sits after a memory reader. It receives 64-bit words on a valid/ready stream and reads them as one continuous byte string. That string holds variable-length output-event write records packed end to end. For each record the block presents a channel number, a timestamp, a register address and a payload of 1 to 64 bytes on a valid/ready record port. The payload is carried in a 512-bit field together with its byte count.

Records are self-sized. A leading length byte counts the whole record, including the length byte itself. Records are not aligned, so any field may begin in one word and end in the next. A length byte of zero ends the sequence. The block then raises a done flag and stops taking words. A malformed length raises a sticky error flag and also stops the block. A one-cycle start pulse clears both flags, discards any buffered bytes and any partly built record, and makes the block expect a length byte again.

Back-pressure works in both directions. A word transfers on a cycle where `in_valid` and `in_ready` are both high. A record transfers on a cycle where `rec_valid` and `rec_ready` are both high. Once `rec_valid` is raised it stays high, with all record fields frozen, until the record is taken. While a record waits, `in_ready` stays low. The decoder consumes one byte per cycle. It can accept a new word in the same cycle that it consumes the last byte of the current word.

Top module: `rec_stream_decoder`

## Requirements
- R1: A record is a length byte L, then a 3-byte channel, an 8-byte timestamp, a 1-byte address and L-13 payload bytes. Each multi-byte field arrives least-significant byte first.
- R2: Within each input word, the earliest byte of the string is bits [63:56] and the latest is bits [7:0].
- R3: Records and their fields may cross word boundaries. Consecutive words are decoded as one unbroken byte string, and no byte is lost or repeated.
- R4: `rec_len` equals L-13. Payload byte i appears at `rec_data[8*i+7:8*i]`, and every byte at or above `rec_len` is zero.
- R5: A length byte of 0 produces no record. It sets `seq_done`, and `in_ready` then stays low until start.
- R6: A length byte from 1 to 13, or above 77, produces no record. It sets `fmt_err`, which holds, along with `in_ready` low, until start.
- R7: While `rec_valid` is high and `rec_ready` is low, `rec_valid` stays high, all record fields hold their values, and `in_ready` is low.
- R8: A start pulse clears `seq_done` and `fmt_err`, drops any buffered bytes and any partial record, and returns the block to expecting a length byte.
- R9: After reset, `in_ready` is high and `rec_valid`, `seq_done` and `fmt_err` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | One-cycle pulse that restarts decoding |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Decoder can take a word |
| in_word | input | 64 | Packed input word, earliest byte in the top lane |
| rec_valid | output | 1 | A decoded record is presented |
| rec_ready | input | 1 | Consumer takes the record |
| rec_channel | output | 24 | Record channel number |
| rec_timestamp | output | 64 | Record timestamp |
| rec_addr | output | 8 | Record register address |
| rec_len | output | 7 | Payload byte count, 1 to 64 |
| rec_data | output | 512 | Payload, byte 0 in the low lane, zero above `rec_len` |
| seq_done | output | 1 | Terminator seen, sticky until start |
| fmt_err | output | 1 | Bad length seen, sticky until start |

## Verification
Two events can fall in the same cycle: the buffer loads a new input word, and the decoder consumes the final byte of the previous word. Holding `in_valid` high across a long stream of records makes this happen on every eighth byte. Payloads of 1, 2, 7, 8, 33 and 64 bytes shift the record boundaries to different lanes at those refills. Every decoded field is compared against values the bench builds from the table, so a byte lost or repeated at a refill shows up as a corrupted field. A second overlap is tested as well: a record finishes while the consumer is stalled. There the bench checks that `in_ready` is low and that `rec_valid` holds through the stall.

// File: rtl/rec_dec_pkg.sv
package rec_dec_pkg;
  localparam int CH_BYTES  = 3;
  localparam int TS_BYTES  = 8;
  localparam int AD_BYTES  = 1;
  localparam int HDR_BYTES = 1 + CH_BYTES + TS_BYTES + AD_BYTES;

  typedef enum logic [2:0] {
    ST_LEN,
    ST_BODY,
    ST_HOLD,
    ST_DONE,
    ST_ERR
  } dec_state_t;
endpackage

// File: rtl/byte_unpacker.sv
module byte_unpacker #(
  parameter int WORD_BYTES = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    flush,
  input  logic                    enable,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic [WORD_BYTES*8-1:0] in_word,
  output logic                    byte_valid,
  output logic [7:0]              byte_data,
  input  logic                    byte_take
);
  localparam int W  = WORD_BYTES * 8;
  localparam int CW = $clog2(WORD_BYTES + 1);

  logic [W-1:0]  buf_q;
  logic [CW-1:0] cnt_q;
  logic          last_take;
  logic          load;

  assign last_take  = (cnt_q == CW'(1)) && byte_take;
  assign in_ready   = enable && ((cnt_q == '0) || last_take);
  assign load       = in_valid && in_ready;
  assign byte_valid = (cnt_q != '0);
  assign byte_data  = buf_q[W-1 -: 8];

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      cnt_q <= '0;
      buf_q <= '0;
    end else if (load) begin
      buf_q <= in_word;
      cnt_q <= CW'(WORD_BYTES);
    end else if (byte_take) begin
      buf_q <= buf_q << 8;
      cnt_q <= cnt_q - CW'(1);
    end
  end

  // R3: bytes are only consumed when present, and the count never exceeds a word
  a_r3_take_needs_byte: assert property (@(posedge clk) disable iff (rst)
    byte_take |-> byte_valid);
  a_r3_count_bound: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= CW'(WORD_BYTES));
  a_r3_refill_full: assert property (@(posedge clk) disable iff (rst)
    (load && !flush) |=> (cnt_q == CW'(WORD_BYTES)));
endmodule

// File: rtl/record_assembler.sv
module record_assembler
  import rec_dec_pkg::*;
#(
  parameter int MAX_DATA = 64
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           start,
  input  logic                           byte_valid,
  input  logic [7:0]                     byte_data,
  output logic                           byte_take,
  output logic                           rec_valid,
  input  logic                           rec_ready,
  output logic [CH_BYTES*8-1:0]          rec_channel,
  output logic [TS_BYTES*8-1:0]          rec_timestamp,
  output logic [AD_BYTES*8-1:0]          rec_addr,
  output logic [$clog2(MAX_DATA+1)-1:0]  rec_len,
  output logic [MAX_DATA*8-1:0]          rec_data,
  output logic                           done,
  output logic                           fmt_err
);
  localparam int DW      = MAX_DATA * 8;
  localparam int LW      = $clog2(MAX_DATA + 1);
  localparam int MAX_LEN = HDR_BYTES + MAX_DATA;
  localparam int TS_POS  = 1 + CH_BYTES;
  localparam int AD_POS  = TS_POS + TS_BYTES;

  dec_state_t              state_q;
  logic [7:0]              len_q;
  logic [7:0]              idx_q;
  logic [CH_BYTES*8-1:0]   ch_q;
  logic [TS_BYTES*8-1:0]   ts_q;
  logic [AD_BYTES*8-1:0]   ad_q;
  logic [DW-1:0]           data_q;
  logic                    len_bad;

  assign byte_take = byte_valid && !start &&
                     ((state_q == ST_LEN) || (state_q == ST_BODY));
  assign len_bad   = (byte_data <= 8'(HDR_BYTES)) || (byte_data > 8'(MAX_LEN));

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_LEN;
      len_q   <= '0;
      idx_q   <= '0;
      ch_q    <= '0;
      ts_q    <= '0;
      ad_q    <= '0;
      data_q  <= '0;
    end else if (start) begin
      state_q <= ST_LEN;
    end else begin
      case (state_q)
        ST_LEN: if (byte_take) begin
          if (byte_data == 8'd0) begin
            state_q <= ST_DONE;
          end else if (len_bad) begin
            state_q <= ST_ERR;
          end else begin
            len_q   <= byte_data;
            idx_q   <= 8'd1;
            data_q  <= '0;
            state_q <= ST_BODY;
          end
        end
        ST_BODY: if (byte_take) begin
          for (int i = 0; i < CH_BYTES; i++)
            if (idx_q == 8'(1 + i)) ch_q[8*i +: 8] <= byte_data;
          for (int i = 0; i < TS_BYTES; i++)
            if (idx_q == 8'(TS_POS + i)) ts_q[8*i +: 8] <= byte_data;
          for (int i = 0; i < AD_BYTES; i++)
            if (idx_q == 8'(AD_POS + i)) ad_q[8*i +: 8] <= byte_data;
          for (int i = 0; i < MAX_DATA; i++)
            if (idx_q == 8'(HDR_BYTES + i)) data_q[8*i +: 8] <= byte_data;
          idx_q <= idx_q + 8'd1;
          if (idx_q == len_q - 8'd1) state_q <= ST_HOLD;
        end
        ST_HOLD: if (rec_ready) state_q <= ST_LEN;
        default: state_q <= state_q;
      endcase
    end
  end

  assign rec_valid     = (state_q == ST_HOLD);
  assign rec_channel   = ch_q;
  assign rec_timestamp = ts_q;
  assign rec_addr      = ad_q;
  assign rec_data      = data_q;
  assign rec_len       = LW'(len_q - 8'(HDR_BYTES));
  assign done          = (state_q == ST_DONE);
  assign fmt_err       = (state_q == ST_ERR);

  // R7: a presented record is frozen until taken
  a_r7_hold_stable: assert property (@(posedge clk) disable iff (rst)
    (rec_valid && !rec_ready && !start) |=>
      (rec_valid && $stable(rec_data) && $stable(rec_channel) &&
       $stable(rec_timestamp) && $stable(rec_addr) && $stable(rec_len)));
  // R4: payload size always in range while presented
  a_r4_len_range: assert property (@(posedge clk) disable iff (rst)
    rec_valid |-> ((rec_len >= LW'(1)) && (rec_len <= LW'(MAX_DATA))));
  // R5: terminator state is sticky
  a_r5_done_sticky: assert property (@(posedge clk) disable iff (rst)
    (done && !start) |=> done);
  // R6: error state is sticky
  a_r6_err_sticky: assert property (@(posedge clk) disable iff (rst)
    (fmt_err && !start) |=> fmt_err);
  // R8: start leaves the decoder expecting a length byte
  a_r8_start_clears: assert property (@(posedge clk) disable iff (rst)
    start |=> (!done && !fmt_err && !rec_valid));
endmodule

// File: rtl/rec_stream_decoder.sv
module rec_stream_decoder
  import rec_dec_pkg::*;
#(
  parameter int WORD_BYTES = 8,
  parameter int MAX_DATA   = 64
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           start,
  input  logic                           in_valid,
  output logic                           in_ready,
  input  logic [WORD_BYTES*8-1:0]        in_word,
  output logic                           rec_valid,
  input  logic                           rec_ready,
  output logic [CH_BYTES*8-1:0]          rec_channel,
  output logic [TS_BYTES*8-1:0]          rec_timestamp,
  output logic [AD_BYTES*8-1:0]          rec_addr,
  output logic [$clog2(MAX_DATA+1)-1:0]  rec_len,
  output logic [MAX_DATA*8-1:0]          rec_data,
  output logic                           seq_done,
  output logic                           fmt_err
);
  logic       byte_valid;
  logic [7:0] byte_data;
  logic       byte_take;
  logic       unpack_en;

  assign unpack_en = !start && !rec_valid && !seq_done && !fmt_err;

  byte_unpacker #(.WORD_BYTES(WORD_BYTES)) unpack_i (
    .clk        (clk),
    .rst        (rst),
    .flush      (start),
    .enable     (unpack_en),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .in_word    (in_word),
    .byte_valid (byte_valid),
    .byte_data  (byte_data),
    .byte_take  (byte_take)
  );

  record_assembler #(.MAX_DATA(MAX_DATA)) asm_i (
    .clk           (clk),
    .rst           (rst),
    .start         (start),
    .byte_valid    (byte_valid),
    .byte_data     (byte_data),
    .byte_take     (byte_take),
    .rec_valid     (rec_valid),
    .rec_ready     (rec_ready),
    .rec_channel   (rec_channel),
    .rec_timestamp (rec_timestamp),
    .rec_addr      (rec_addr),
    .rec_len       (rec_len),
    .rec_data      (rec_data),
    .done          (seq_done),
    .fmt_err       (fmt_err)
  );

  // R7: no word is taken while a record waits
  a_r7_ready_low: assert property (@(posedge clk) disable iff (rst)
    rec_valid |-> !in_ready);
  // R5/R6: a halted decoder takes no words
  a_r5_halt_ready: assert property (@(posedge clk) disable iff (rst)
    (seq_done || fmt_err) |-> !in_ready);
  a_r6_one_flag: assert property (@(posedge clk) disable iff (rst)
    $onehot0({seq_done, fmt_err, rec_valid}));
endmodule

// File: tb/rec_stream_decoder_tb.sv
module rec_stream_decoder_tb_top;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         start = 1'b0;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [63:0]  in_word = '0;
  logic         rec_valid;
  logic         rec_ready = 1'b0;
  logic [23:0]  rec_channel;
  logic [63:0]  rec_timestamp;
  logic [7:0]   rec_addr;
  logic [6:0]   rec_len;
  logic [511:0] rec_data;
  logic         seq_done;
  logic         fmt_err;

  int checks = 0;
  int failures = 0;

  always #2 clk = ~clk;

  rec_stream_decoder dut_i (
    .clk(clk), .rst(rst), .start(start),
    .in_valid(in_valid), .in_ready(in_ready), .in_word(in_word),
    .rec_valid(rec_valid), .rec_ready(rec_ready),
    .rec_channel(rec_channel), .rec_timestamp(rec_timestamp),
    .rec_addr(rec_addr), .rec_len(rec_len), .rec_data(rec_data),
    .seq_done(seq_done), .fmt_err(fmt_err)
  );

  // entry: {channel[24], timestamp[64], addr[8], payload bytes[7], seed[8]}
  localparam int NVEC = 6;
  localparam logic [110:0] VEC [0:NVEC-1] = '{
    {24'h000001, 64'h0000000000000023, 8'h12, 7'd1,  8'h33},
    {24'h000901, 64'h0000000000000902, 8'h11, 7'd64, 8'h5A},
    {24'hABCDEF, 64'h0123456789ABCDEF, 8'hFE, 7'd7,  8'h01},
    {24'h000081, 64'h0000000000000288, 8'h88, 7'd2,  8'h88},
    {24'h7FFFFF, 64'hFFFFFFFFFFFFFFFF, 8'h00, 7'd8,  8'hC0},
    {24'h010203, 64'h0000000000010000, 8'h20, 7'd33, 8'h77}
  };

  logic [7:0]   sb [0:1023];
  int           sn;
  logic [23:0]  e_ch [0:15];
  logic [63:0]  e_ts [0:15];
  logic [7:0]   e_ad [0:15];
  logic [6:0]   e_n  [0:15];
  logic [511:0] e_dt [0:15];
  int           n_exp;

  task automatic chk(input bit ok, input string tag, input logic [511:0] act,
                     input logic [511:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic push(input logic [7:0] b);
    sb[sn] = b;
    sn++;
  endtask

  task automatic add_rec(input logic [110:0] v);
    logic [23:0] ch; logic [63:0] ts; logic [7:0] ad; logic [6:0] n; logic [7:0] sd;
    logic [511:0] d;
    ch = v[110:87]; ts = v[86:23]; ad = v[22:15]; n = v[14:8]; sd = v[7:0];
    d = '0;
    push(8'(13 + int'(n)));
    for (int i = 0; i < 3; i++) push(ch[8*i +: 8]);
    for (int i = 0; i < 8; i++) push(ts[8*i +: 8]);
    push(ad);
    for (int i = 0; i < int'(n); i++) begin
      push(8'(sd + 8'(i * 7)));
      d[8*i +: 8] = 8'(sd + 8'(i * 7));
    end
    e_ch[n_exp] = ch; e_ts[n_exp] = ts; e_ad[n_exp] = ad;
    e_n[n_exp] = n; e_dt[n_exp] = d;
    n_exp++;
  endtask

  task automatic send_stream();
    logic [63:0] w;
    bit ok;
    while (sn % 8 != 0) push(8'h00);
    for (int k = 0; k < sn / 8; k++) begin
      for (int j = 0; j < 8; j++) w[63 - 8*j -: 8] = sb[8*k + j];
      ok = 1'b0;
      while (!ok) begin
        @(negedge clk);
        in_valid = 1'b1;
        in_word = w;
        #1 ok = in_ready;
        @(posedge clk);
      end
    end
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic recv_all();
    for (int j = 0; j < n_exp; j++) begin
      do begin @(negedge clk); #1; end while (!rec_valid);
      chk(in_ready == 1'b0, "R7 in_ready low while record waits", 512'(in_ready), 512'(0));
      for (int s = 0; s < (j * 2) % 5; s++) begin
        @(negedge clk); #1;
        chk(rec_valid == 1'b1, "R7 valid held under stall", 512'(rec_valid), 512'(1));
      end
      chk(rec_channel == e_ch[j], "R1 channel", 512'(rec_channel), 512'(e_ch[j]));
      chk(rec_timestamp == e_ts[j], "R2 timestamp byte order", 512'(rec_timestamp), 512'(e_ts[j]));
      chk(rec_addr == e_ad[j], "R1 address", 512'(rec_addr), 512'(e_ad[j]));
      chk(rec_len == e_n[j], "R4 payload length", 512'(rec_len), 512'(e_n[j]));
      chk(rec_data == e_dt[j], "R3 R4 payload across words, zero fill", rec_data, e_dt[j]);
      rec_ready = 1'b1;
      @(negedge clk);
      rec_ready = 1'b0;
    end
  endtask

  task automatic pulse_start();
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    sn = 0; n_exp = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
    // R9 reset state
    chk(in_ready == 1'b1, "R9 in_ready after reset", 512'(in_ready), 512'(1));
    chk(rec_valid == 1'b0, "R9 rec_valid after reset", 512'(rec_valid), 512'(0));
    chk(seq_done == 1'b0, "R9 seq_done after reset", 512'(seq_done), 512'(0));
    chk(fmt_err == 1'b0, "R9 fmt_err after reset", 512'(fmt_err), 512'(0));

    // table walk: all records in one packed stream
    for (int v = 0; v < NVEC; v++) add_rec(VEC[v]);
    push(8'h00);
    fork
      send_stream();
      recv_all();
    join
    idle(4);
    chk(seq_done == 1'b1, "R5 done after terminator", 512'(seq_done), 512'(1));
    chk(in_ready == 1'b0, "R5 in_ready low after terminator", 512'(in_ready), 512'(0));
    chk(rec_valid == 1'b0, "R5 no record for terminator", 512'(rec_valid), 512'(0));

    pulse_start();
    #1;
    chk(seq_done == 1'b0, "R8 start clears done", 512'(seq_done), 512'(0));
    chk(in_ready == 1'b1, "R8 in_ready after start", 512'(in_ready), 512'(1));

    // bad lengths
    for (int e = 0; e < 4; e++) begin
      logic [7:0] bl;
      bl = (e == 0) ? 8'd1 : (e == 1) ? 8'd13 : (e == 2) ? 8'd78 : 8'd255;
      sn = 0; n_exp = 0;
      push(bl);
      for (int i = 0; i < 7; i++) push(8'h11);
      send_stream();
      idle(12);
      chk(fmt_err == 1'b1, "R6 bad length flagged", 512'(fmt_err), 512'(1));
      chk(rec_valid == 1'b0, "R6 no record on bad length", 512'(rec_valid), 512'(0));
      chk(in_ready == 1'b0, "R6 in_ready low in error", 512'(in_ready), 512'(0));
      idle(20);
      chk(fmt_err == 1'b1, "R6 error sticky", 512'(fmt_err), 512'(1));
      pulse_start();
      #1;
      chk(fmt_err == 1'b0, "R8 start clears error", 512'(fmt_err), 512'(0));
    end

    // start abandons a partial record and buffered bytes
    sn = 0; n_exp = 0;
    push(8'd20);
    for (int i = 0; i < 7; i++) push(8'hEE);
    send_stream();
    idle(3);
    pulse_start();
    sn = 0; n_exp = 0;
    add_rec(VEC[2]);
    add_rec(VEC[0]);
    push(8'h00);
    fork
      send_stream();
      recv_all();
    join
    idle(4);
    chk(seq_done == 1'b1, "R8 fresh stream decodes after start", 512'(seq_done), 512'(1));
    chk(fmt_err == 1'b0, "R8 no stale bytes after start", 512'(fmt_err), 512'(0));

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule